// File: doc/BRIEF.md
# Coherence Directory Controller

This block is the home-node directory for a small directory-based cache coherence system. For every memory block it holds, it keeps a coherence state and a sharer bit vector with one bit per processor. It also holds a small backing memory with one data word per block. Caches send it read misses, write misses and write-backs. It handles one request at a time. For each request it updates the directory entry, sends any invalidate, fetch or fetch-with-invalidate messages that are needed to other caches, and then answers the requester.

Outgoing messages leave on a single message port, one per cycle. Each message carries a type, a destination processor index, the block address and a data word. When the block is held dirty by another cache, the controller stops and waits on a fetch-response port for that cache's data. It writes the returned data into memory and then forwards it to the requester. The request input is held off (ready low) from the cycle after acceptance until the cycle after the final response. This makes every request atomic as seen by the rest of the system.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset, every block is in the Uncached state (code 0) with an empty sharer vector and a memory word of zero. `req_ready_o` is high and `msg_valid_o` is low.
- R2: A read miss (request code 0) to an Uncached or Shared (code 1) block sends only a data reply (message code 0) to the requester, carrying the memory word. The block becomes Shared and the requester is added to its sharers.
- R3: A read miss to an Exclusive (code 2) block sends one fetch (message code 2) to the owner and then waits for `fetch_valid_i`. It stores `fetch_data_i` in memory and replies with that data. The block becomes Shared, with the old owner and the requester as its sharers.
- R4: A write miss (request code 1) to a Shared block sends one invalidate (message code 1) per cycle to every sharer other than the requester, in ascending processor index. It then sends the data reply. The block becomes Exclusive and the requester is its only sharer.
- R5: A write miss from the only sharer of a Shared block sends no invalidate. It sends only the data reply and makes the block Exclusive to that requester.
- R6: A write miss to a block held Exclusive by another processor sends one fetch-with-invalidate (message code 3) to the old owner. After the fetch response arrives, it stores that data and replies with it to the requester. The requester becomes the only sharer.
- R7: A write-back (request code 2) from the Exclusive owner writes its data word into memory and returns the block to Uncached with no sharers. It is acknowledged with message code 4.
- R8: A write-back from a processor that is not the Exclusive owner is still acknowledged with code 4. It changes neither the memory word nor the directory entry. Request code 3 is handled the same way.
- R9: After a request is accepted, `req_ready_o` stays low until the cycle after its final response (data reply or acknowledge). Exactly one final response is sent per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle and able to accept a request |
| req_type_i | input | 2 | Request code: 0 read miss, 1 write miss, 2 write-back |
| req_src_i | input | PW | Requesting processor index |
| req_addr_i | input | AW | Block address |
| req_data_i | input | DATA_W | Write-back data word |
| fetch_valid_i | input | 1 | Owner's fetch response present |
| fetch_data_i | input | DATA_W | Data returned by the owner |
| msg_valid_o | output | 1 | Outgoing message valid this cycle |
| msg_type_o | output | 3 | Message code: 0 reply, 1 invalidate, 2 fetch, 3 fetch-invalidate, 4 write-back acknowledge |
| msg_dst_o | output | PW | Destination processor index |
| msg_addr_o | output | AW | Block address |
| msg_data_o | output | DATA_W | Reply data (zero for other messages) |

## Verification
The bench focuses on the ownership transitions that are easy to get wrong.

- **Upgrade by the sole sharer.** A design that sends invalidates here would invalidate the requester's own copy.
- **Read of a dirty block.** A design that skips the fetch would return stale memory. A design that drops the old owner from the sharers would let a later write miss skip invalidating it.
- **Write-back from a non-owner.** A design that accepts it would corrupt memory. It would also downgrade a block that someone still holds dirty, which a later read exposes because no fetch goes to the true owner.
- **Invalidate order and the ready window.** The order is checked by index. `req_ready_o` is watched through every busy cycle.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
  typedef enum logic [1:0] {
    DIR_UNC = 2'd0,
    DIR_SHR = 2'd1,
    DIR_EXC = 2'd2
  } dir_state_e;

  localparam logic [1:0] REQ_RD = 2'd0;
  localparam logic [1:0] REQ_WR = 2'd1;
  localparam logic [1:0] REQ_WB = 2'd2;

  localparam logic [2:0] MSG_REPLY = 3'd0;
  localparam logic [2:0] MSG_INV   = 3'd1;
  localparam logic [2:0] MSG_FETCH = 3'd2;
  localparam logic [2:0] MSG_FINV  = 3'd3;
  localparam logic [2:0] MSG_ACK   = 3'd4;
endpackage

// File: rtl/coh_dir_lsb.sv
module coh_dir_lsb #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec_i,
  output logic [W-1:0] idx_o,
  output logic         any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (vec_i[i]) idx_o = W'(i);
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/coh_dir_store.sv
module coh_dir_store
  import coh_dir_pkg::*;
#(
  parameter int NUM_PROC = 4,
  parameter int NUM_BLK  = 16,
  parameter int DATA_W   = 16,
  localparam int AW = $clog2(NUM_BLK)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [AW-1:0]       rd_addr_i,
  output dir_state_e          rd_state_o,
  output logic [NUM_PROC-1:0] rd_shr_o,
  output logic [DATA_W-1:0]   rd_data_o,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic                dir_we_i,
  input  dir_state_e          dir_state_i,
  input  logic [NUM_PROC-1:0] dir_shr_i,
  input  logic                mem_we_i,
  input  logic [DATA_W-1:0]   mem_data_i
);
  dir_state_e          state_q [NUM_BLK];
  logic [NUM_PROC-1:0] shr_q   [NUM_BLK];
  logic [DATA_W-1:0]   mem_q   [NUM_BLK];

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        state_q[b] <= DIR_UNC;
        shr_q[b]   <= '0;
        mem_q[b]   <= '0;
      end else begin
        if (dir_we_i && wr_addr_i == AW'(b)) begin
          state_q[b] <= dir_state_i;
          shr_q[b]   <= dir_shr_i;
        end
        if (mem_we_i && wr_addr_i == AW'(b)) mem_q[b] <= mem_data_i;
      end
    end
  end

  assign rd_state_o = state_q[rd_addr_i];
  assign rd_shr_o   = shr_q[rd_addr_i];
  assign rd_data_o  = mem_q[rd_addr_i];

  p_exc_single_owner_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_we_i && dir_state_i == DIR_EXC |-> $countones(dir_shr_i) == 1);
  p_unc_no_sharers_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_we_i && dir_state_i == DIR_UNC |-> dir_shr_i == '0);
  p_shr_nonempty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_we_i && dir_state_i == DIR_SHR |-> dir_shr_i != '0);
endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
  import coh_dir_pkg::*;
#(
  parameter int NUM_PROC = 4,
  parameter int NUM_BLK  = 16,
  parameter int DATA_W   = 16,
  localparam int PW = $clog2(NUM_PROC),
  localparam int AW = $clog2(NUM_BLK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_type_i,
  input  logic [PW-1:0]     req_src_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic              fetch_valid_i,
  input  logic [DATA_W-1:0] fetch_data_i,
  output logic              msg_valid_o,
  output logic [2:0]        msg_type_o,
  output logic [PW-1:0]     msg_dst_o,
  output logic [AW-1:0]     msg_addr_o,
  output logic [DATA_W-1:0] msg_data_o
);
  typedef enum logic [2:0] {S_IDLE, S_INV, S_FETCH, S_WAIT, S_REPLY, S_ACK} fsm_e;

  fsm_e                st_q;
  logic [1:0]          typ_q;
  logic [PW-1:0]       src_q, owner_q;
  logic [AW-1:0]       addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [NUM_PROC-1:0] inv_mask_q, nxt_shr_q;
  dir_state_e          nxt_st_q;
  logic                wb_ok_q;

  logic [AW-1:0]       rd_addr;
  dir_state_e          rd_state;
  logic [NUM_PROC-1:0] rd_shr, src_oh, others;
  logic [DATA_W-1:0]   rd_data, mem_wdata;
  logic [PW-1:0]       owner_idx, inv_idx;
  logic                owner_any, inv_any;
  logic                dir_we, mem_we;
  dir_state_e          dir_wstate;
  logic [NUM_PROC-1:0] dir_wshr;
  logic                accept;

  assign accept  = (st_q == S_IDLE) && req_valid_i;
  assign rd_addr = (st_q == S_IDLE) ? req_addr_i : addr_q;
  assign src_oh  = NUM_PROC'(1) << req_src_i;
  assign others  = rd_shr & ~src_oh;

  coh_dir_store #(.NUM_PROC(NUM_PROC), .NUM_BLK(NUM_BLK), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .rd_addr_i  (rd_addr),
    .rd_state_o (rd_state),
    .rd_shr_o   (rd_shr),
    .rd_data_o  (rd_data),
    .wr_addr_i  (addr_q),
    .dir_we_i   (dir_we),
    .dir_state_i(dir_wstate),
    .dir_shr_i  (dir_wshr),
    .mem_we_i   (mem_we),
    .mem_data_i (mem_wdata)
  );

  coh_dir_lsb #(.N(NUM_PROC)) u_owner_enc (.vec_i(rd_shr),     .idx_o(owner_idx), .any_o(owner_any));
  coh_dir_lsb #(.N(NUM_PROC)) u_inv_enc   (.vec_i(inv_mask_q), .idx_o(inv_idx),   .any_o(inv_any));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      typ_q      <= REQ_RD;
      src_q      <= '0;
      owner_q    <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      inv_mask_q <= '0;
      nxt_shr_q  <= '0;
      nxt_st_q   <= DIR_UNC;
      wb_ok_q    <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (accept) begin
          typ_q   <= req_type_i;
          src_q   <= req_src_i;
          addr_q  <= req_addr_i;
          wdata_q <= req_data_i;
          owner_q <= owner_idx;
          wb_ok_q <= 1'b0;
          if (req_type_i == REQ_RD) begin
            nxt_st_q  <= DIR_SHR;
            nxt_shr_q <= rd_shr | src_oh;
            st_q      <= (rd_state == DIR_EXC && owner_any) ? S_FETCH : S_REPLY;
          end else if (req_type_i == REQ_WR) begin
            nxt_st_q   <= DIR_EXC;
            nxt_shr_q  <= src_oh;
            inv_mask_q <= others;
            if (rd_state == DIR_EXC && others != '0)      st_q <= S_FETCH;
            else if (rd_state == DIR_SHR && others != '0) st_q <= S_INV;
            else                                          st_q <= S_REPLY;
          end else begin
            // only the recorded owner of a dirty block may retire it
            wb_ok_q <= (req_type_i == REQ_WB) && (rd_state == DIR_EXC) && (rd_shr == src_oh);
            st_q    <= S_ACK;
          end
        end
        S_INV: begin
          inv_mask_q[inv_idx] <= 1'b0;
          if ((inv_mask_q & ~(NUM_PROC'(1) << inv_idx)) == '0) st_q <= S_REPLY;
        end
        S_FETCH: st_q <= S_WAIT;
        S_WAIT:  if (fetch_valid_i) st_q <= S_REPLY;
        S_REPLY: st_q <= S_IDLE;
        S_ACK:   st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    dir_we     = 1'b0;
    dir_wstate = nxt_st_q;
    dir_wshr   = nxt_shr_q;
    mem_we     = 1'b0;
    mem_wdata  = fetch_data_i;
    msg_valid_o = 1'b0;
    msg_type_o  = MSG_REPLY;
    msg_dst_o   = src_q;
    msg_data_o  = '0;
    unique case (st_q)
      S_INV: begin
        msg_valid_o = inv_any;
        msg_type_o  = MSG_INV;
        msg_dst_o   = inv_idx;
      end
      S_FETCH: begin
        msg_valid_o = 1'b1;
        msg_type_o  = (typ_q == REQ_WR) ? MSG_FINV : MSG_FETCH;
        msg_dst_o   = owner_q;
      end
      S_WAIT: mem_we = fetch_valid_i;
      S_REPLY: begin
        msg_valid_o = 1'b1;
        msg_data_o  = rd_data;
        dir_we      = 1'b1;
      end
      S_ACK: begin
        msg_valid_o = 1'b1;
        msg_type_o  = MSG_ACK;
        dir_we      = wb_ok_q;
        dir_wstate  = DIR_UNC;
        dir_wshr    = '0;
        mem_we      = wb_ok_q;
        mem_wdata   = wdata_q;
      end
      default: ;
    endcase
  end

  assign req_ready_o = (st_q == S_IDLE);
  assign msg_addr_o  = addr_q;

  p_busy_after_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);
  p_final_then_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && (msg_type_o == MSG_REPLY || msg_type_o == MSG_ACK) |=> req_ready_o);
  p_fetch_then_wait_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && (msg_type_o == MSG_FETCH || msg_type_o == MSG_FINV) |=> !msg_valid_o);
  p_inv_to_sharer_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_type_o == MSG_INV |-> inv_mask_q[msg_dst_o] && msg_dst_o != src_q);
  p_inv_unique_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_type_o == MSG_INV |=> !inv_mask_q[$past(msg_dst_o)]);
  p_no_msg_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !msg_valid_o);
endmodule

// File: tb/coh_dir_ctrl_test.sv
module coh_dir_ctrl_test;
  localparam int NP = 4, NB = 16, DW = 16;
  localparam int PW = $clog2(NP), AW = $clog2(NB);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_type = '0;
  logic [PW-1:0] req_src = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic fetch_valid = 1'b0;
  logic [DW-1:0] fetch_data = '0;
  logic msg_valid;
  logic [2:0] msg_type;
  logic [PW-1:0] msg_dst;
  logic [AW-1:0] msg_addr;
  logic [DW-1:0] msg_data;

  int checks = 0, errors = 0;
  int n_inv, inv_seq [8], n_fetch, fetch_kind, fetch_dst;
  int resp_type, resp_dst, resp_data, n_resp, ready_bad;

  always #10 clk = ~clk;

  coh_dir_ctrl #(.NUM_PROC(NP), .NUM_BLK(NB), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_type_i(req_type),
    .req_src_i(req_src), .req_addr_i(req_addr), .req_data_i(req_data),
    .fetch_valid_i(fetch_valid), .fetch_data_i(fetch_data),
    .msg_valid_o(msg_valid), .msg_type_o(msg_type), .msg_dst_o(msg_dst),
    .msg_addr_o(msg_addr), .msg_data_o(msg_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // issue one request and gather all messages up to its final response
  task automatic do_req(input int t, input int src, input int addr, input int data, input int fdata);
    bit drive_fetch = 0;
    n_inv = 0; n_fetch = 0; n_resp = 0; ready_bad = 0;
    fetch_kind = -1; fetch_dst = -1; resp_type = -1; resp_dst = -1; resp_data = -1;
    @(negedge clk);
    req_valid = 1'b1; req_type = 2'(t); req_src = PW'(src);
    req_addr = AW'(addr); req_data = DW'(data);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int cyc = 0; cyc < 40 && n_resp == 0; cyc++) begin
      if (cyc > 0) @(negedge clk);
      fetch_valid = 1'b0;
      if (drive_fetch) begin
        fetch_valid = 1'b1; fetch_data = DW'(fdata); drive_fetch = 0;
      end
      if (req_ready) ready_bad++;
      if (msg_valid) begin
        if (msg_addr != AW'(addr)) ready_bad++;
        case (msg_type)
          3'd1: begin if (n_inv < 8) inv_seq[n_inv] = int'(msg_dst); n_inv++; end
          3'd2, 3'd3: begin n_fetch++; fetch_kind = int'(msg_type); fetch_dst = int'(msg_dst); drive_fetch = 1; end
          default: begin n_resp++; resp_type = int'(msg_type); resp_dst = int'(msg_dst); resp_data = int'(msg_data); end
        endcase
      end
    end
    @(negedge clk);
    fetch_valid = 1'b0;
    chk(req_ready, "R9 ready after response", int'(req_ready), 1);
    chk(ready_bad == 0, "R9 ready low while busy", ready_bad, 0);
    chk(n_resp == 1, "R9 one final response", n_resp, 1);
  endtask

  task automatic t_reset;
    chk(req_ready === 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(msg_valid === 1'b0, "R1 no message after reset", int'(msg_valid), 0);
    do_req(0, 0, 1, 0, 0);
    chk(resp_type == 0 && resp_dst == 0, "R2 reply to reader", resp_dst, 0);
    chk(resp_data == 0, "R1 memory zero", resp_data, 0);
    chk(n_inv == 0 && n_fetch == 0, "R1 uncached needs no fetch", n_fetch + n_inv, 0);
    do_req(0, 1, 7, 0, 0);
    chk(resp_data == 0 && n_fetch == 0, "R1 other block uncached zero", resp_data, 0);
  endtask

  task automatic t_upgrade;
    do_req(1, 0, 1, 0, 0);
    chk(n_inv == 0, "R5 sole sharer upgrade no inval", n_inv, 0);
    chk(resp_type == 0 && resp_dst == 0, "R5 reply to upgrader", resp_dst, 0);
  endtask

  task automatic t_read_dirty;
    do_req(0, 1, 1, 0, 10);
    chk(n_fetch == 1 && fetch_kind == 2, "R3 fetch sent", fetch_kind, 2);
    chk(fetch_dst == 0, "R3 fetch to owner", fetch_dst, 0);
    chk(resp_dst == 1 && resp_data == 10, "R3 reply fetched data", resp_data, 10);
    do_req(0, 2, 1, 0, 0);
    chk(n_fetch == 0 && resp_data == 10, "R2 shared read from memory", resp_data, 10);
  endtask

  task automatic t_write_shared;
    do_req(1, 2, 1, 0, 0);
    chk(n_inv == 2, "R4 inval count", n_inv, 2);
    chk(inv_seq[0] == 0, "R4 first inval", inv_seq[0], 0);
    chk(inv_seq[1] == 1, "R4 second inval", inv_seq[1], 1);
    chk(n_fetch == 0 && resp_dst == 2 && resp_data == 10, "R4 reply to writer", resp_data, 10);
  endtask

  task automatic t_write_dirty;
    do_req(1, 3, 1, 0, 20);
    chk(n_fetch == 1 && fetch_kind == 3, "R6 fetch-inval sent", fetch_kind, 3);
    chk(fetch_dst == 2, "R6 fetch-inval to old owner", fetch_dst, 2);
    chk(n_inv == 0 && resp_dst == 3 && resp_data == 20, "R6 reply forwarded", resp_data, 20);
  endtask

  task automatic t_wb_stranger;
    do_req(2, 1, 1, 99, 0);
    chk(resp_type == 4 && resp_dst == 1, "R8 stranger write-back acked", resp_type, 4);
    do_req(3, 0, 1, 77, 0);
    chk(resp_type == 4, "R8 code 3 acked", resp_type, 4);
    do_req(0, 0, 1, 0, 30);
    chk(n_fetch == 1 && fetch_dst == 3, "R8 owner unchanged", fetch_dst, 3);
    chk(resp_data == 30, "R8 memory not overwritten", resp_data, 30);
  endtask

  task automatic t_wb_owner;
    do_req(1, 0, 1, 0, 0);
    chk(n_inv == 1 && inv_seq[0] == 3, "R4 inval old sharer", inv_seq[0], 3);
    do_req(2, 0, 1, 55, 0);
    chk(resp_type == 4 && resp_dst == 0, "R7 owner write-back acked", resp_type, 4);
    do_req(0, 2, 1, 0, 0);
    chk(n_fetch == 0, "R7 block uncached after write-back", n_fetch, 0);
    chk(resp_data == 55, "R7 memory updated", resp_data, 55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_upgrade();
    t_read_dirty();
    t_write_shared();
    t_write_dirty();
    t_wb_stranger();
    t_wb_owner();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule